// File: doc/BRIEF.md
# Multicycle Integer Subset Core

A small processor core that runs a six-instruction integer subset (add, sub, load word, store word, branch-if-equal and jump) over several clock cycles per instruction. Every instruction passes through a fetch cycle and a decode cycle, then one to three further cycles chosen by its opcode. Instructions and data share one memory port, which is read combinationally: the read word is due in the same cycle as the address.

Every architectural holding register (program counter, instruction, memory data, two operand latches and the ALU result latch) is brought out, as is every control line of the state machine. The operand latches and the ALU result latch are loaded on every cycle, whatever the state. The memory data latch clears on any cycle without a memory read. This makes the cycle-by-cycle contents of every holding register fully determined. The block is therefore suited to stepping through a program and comparing each cycle against a hand-worked trace.

Top module: `mcyc_core`

## Requirements
- R1: In the fetch cycle the core asserts memory read, instruction write and PC write, with address select 0, ALU source A 0 (PC), source B 01 (constant 4), ALU op 00 (add) and PC source 00. At the edge, PC becomes PC+4 and IR takes the read word. IR holds its value in every cycle without instruction write.
- R2: The memory data register loads zero in a cycle without memory read. With memory read it loads the read word, which is the instruction when address select is 0 and the data word at ALUOut when it is 1.
- R3: The A and B latches load on every cycle from the register file. They are addressed by IR bits 25:21 and 20:16 as held at the start of that cycle.
- R4: ALUOut loads the ALU result on every cycle. Source A 0 picks PC and 1 picks A. Source B 00 picks B, 01 picks 4, 10 picks the sign-extended IR[15:0] and 11 picks that value shifted left by 2. ALU op 00 adds, 01 subtracts, and 10 uses IR[5:0] (100010 subtracts, anything else adds). In a state that does not name a select, the select reads zero.
- R5: The decode cycle uses source A 0, source B 11 and ALU op 00, so ALUOut receives the branch target PC+4+(offset<<2).
- R6: Opcode 000100 compares registers over 3 cycles. Its third cycle uses source A 1, source B 00, ALU op 01, PC-write-conditional and PC source 01. PC loads ALUOut only when the difference is zero.
- R7: Opcode 000010 takes 3 cycles. Its third cycle asserts PC write with PC source 10, and PC becomes {PC[31:28], IR[25:0], 2'b00}.
- R8: Opcode 000000 takes 4 cycles. It computes A op B with ALU op 10 (funct 100000 add, 100010 sub), then writes ALUOut into the register at IR[15:11] with register destination 1 and memory-to-register 0.
- R9: Opcode 100011 (load) takes 5 cycles and opcode 101011 (store) takes 4. Both form the address as A plus the sign-extended immediate (source A 1, source B 10). A load reads with address select 1, then writes the memory data register into the register at IR[20:16]. A store writes B to the address in ALUOut. Memory read and memory write are never asserted together.
- R10: Register 0 always reads zero, and a write aimed at it has no effect.
- R11: While reset is low, PC holds the START_PC parameter, IR and the other holding registers are zero, and the state is fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 32 | Shared memory byte address |
| mem_wdata_o | output | 32 | Store data (B latch) |
| mem_rdata_i | input | 32 | Memory read word, same cycle |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| dbg_pc_o | output | 32 | Program counter |
| dbg_ir_o | output | 32 | Instruction register |
| dbg_mdr_o | output | 32 | Memory data register |
| dbg_a_o | output | 32 | Operand latch A |
| dbg_b_o | output | 32 | Operand latch B |
| dbg_alu_out_o | output | 32 | ALU result latch |
| iord_o | output | 1 | Address select (0 PC, 1 ALUOut) |
| ir_wr_o | output | 1 | Instruction register write |
| src_a_o | output | 1 | ALU source A select |
| src_b_o | output | 2 | ALU source B select |
| alu_op_o | output | 2 | ALU operation class |
| pc_src_o | output | 2 | PC source select |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write on zero result |
| reg_dst_o | output | 1 | Destination select (0 rt, 1 rd) |
| mem_to_reg_o | output | 1 | Write-back source (0 ALUOut, 1 MDR) |
| reg_wr_o | output | 1 | Register file write |

## Verification
The control lines are decoded from the current state alone, so they are valid during the cycle they govern. Every holding register is written at the closing edge of that cycle, so its result is due one edge after the controls that produced it. The bench samples the control lines at the falling edge inside a cycle. It samples the six holding registers at the falling edge after the next rising edge, and pairs them with the expected entry for that same cycle. Stores land in memory at that same closing edge and are checked once the program has settled in its final jump loop.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam int RA_W = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] FN_SUB   = 6'b100010;

  localparam logic [1:0] SB_REG  = 2'b00;
  localparam logic [1:0] SB_FOUR = 2'b01;
  localparam logic [1:0] SB_IMM  = 2'b10;
  localparam logic [1:0] SB_OFS  = 2'b11;

  localparam logic [1:0] AO_ADD = 2'b00;
  localparam logic [1:0] AO_SUB = 2'b01;
  localparam logic [1:0] AO_FN  = 2'b10;

  localparam logic [1:0] PS_ALU = 2'b00;
  localparam logic [1:0] PS_OUT = 2'b01;
  localparam logic [1:0] PS_JMP = 2'b10;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_EXEC, S_ALU_WB, S_ADDR,
    S_LOAD, S_LOAD_WB, S_STORE, S_BRANCH, S_JUMP
  } state_e;

  typedef struct packed {
    logic       iord;
    logic       ir_wr;
    logic       mem_rd;
    logic       mem_wr;
    logic       src_a;
    logic [1:0] src_b;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       reg_dst;
    logic       mem_to_reg;
    logic       reg_wr;
  } ctrl_t;
endpackage

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [5:0] opcode_i,
  output ctrl_t      ctrl_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FETCH;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = S_FETCH;
    unique case (state_q)
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: begin
        case (opcode_i)
          OP_RTYPE:     state_d = S_EXEC;
          OP_LW, OP_SW: state_d = S_ADDR;
          OP_BEQ:       state_d = S_BRANCH;
          OP_J:         state_d = S_JUMP;
          default:      state_d = S_FETCH;
        endcase
      end
      S_EXEC:   state_d = S_ALU_WB;
      S_ADDR:   state_d = (opcode_i == OP_LW) ? S_LOAD : S_STORE;
      S_LOAD:   state_d = S_LOAD_WB;
      default:  state_d = S_FETCH;
    endcase
  end

  // unnamed selects stay zero in every state
  always_comb begin
    ctrl_o = '0;
    unique case (state_q)
      S_FETCH: begin
        ctrl_o.mem_rd = 1'b1;
        ctrl_o.ir_wr  = 1'b1;
        ctrl_o.src_b  = SB_FOUR;
        ctrl_o.pc_wr  = 1'b1;
      end
      S_DECODE: ctrl_o.src_b = SB_OFS;
      S_EXEC: begin
        ctrl_o.src_a  = 1'b1;
        ctrl_o.alu_op = AO_FN;
      end
      S_ALU_WB: begin
        ctrl_o.reg_dst = 1'b1;
        ctrl_o.reg_wr  = 1'b1;
      end
      S_ADDR: begin
        ctrl_o.src_a = 1'b1;
        ctrl_o.src_b = SB_IMM;
      end
      S_LOAD: begin
        ctrl_o.mem_rd = 1'b1;
        ctrl_o.iord   = 1'b1;
      end
      S_LOAD_WB: begin
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_wr     = 1'b1;
      end
      S_STORE: begin
        ctrl_o.iord   = 1'b1;
        ctrl_o.mem_wr = 1'b1;
      end
      S_BRANCH: begin
        ctrl_o.src_a      = 1'b1;
        ctrl_o.alu_op     = AO_SUB;
        ctrl_o.pc_wr_cond = 1'b1;
        ctrl_o.pc_src     = PS_OUT;
      end
      S_JUMP: begin
        ctrl_o.pc_wr  = 1'b1;
        ctrl_o.pc_src = PS_JMP;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
  import mcyc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  input  logic [5:0]   funct_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  logic do_sub;

  assign do_sub = (op_i == AO_SUB) || ((op_i == AO_FN) && (funct_i == FN_SUB));
  assign y_o    = do_sub ? (a_i - b_i) : (a_i + b_i);
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
  parameter int W  = 32,
  parameter int N  = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              regs[g] <= '0;
        else if (we_i && (wa_i == AW'(g)))        regs[g] <= wd_i;
      end
    end
  end

  assign rd1_o = regs[ra1_i];
  assign rd2_o = regs[ra2_i];
endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
  import mcyc_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          REG_N    = 32,
  parameter logic [31:0] START_PC = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] dbg_pc_o,
  output logic [DATA_W-1:0] dbg_ir_o,
  output logic [DATA_W-1:0] dbg_mdr_o,
  output logic [DATA_W-1:0] dbg_a_o,
  output logic [DATA_W-1:0] dbg_b_o,
  output logic [DATA_W-1:0] dbg_alu_out_o,
  output logic              iord_o,
  output logic              ir_wr_o,
  output logic              src_a_o,
  output logic [1:0]        src_b_o,
  output logic [1:0]        alu_op_o,
  output logic [1:0]        pc_src_o,
  output logic              pc_wr_o,
  output logic              pc_wr_cond_o,
  output logic              reg_dst_o,
  output logic              mem_to_reg_o,
  output logic              reg_wr_o
);
  localparam int IMM_PAD = DATA_W - 16;

  ctrl_t             c;
  logic [DATA_W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_out_q;
  logic [DATA_W-1:0] imm_ext, op_a, op_b, alu_y, pc_d, rd1, rd2, wd;
  logic [RA_W-1:0]   wa;
  logic              alu_zero, pc_en;

  mcyc_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (ir_q[31:26]),
    .ctrl_o   (c)
  );

  assign imm_ext = {{IMM_PAD{ir_q[15]}}, ir_q[15:0]};
  assign op_a    = c.src_a ? a_q : pc_q;

  always_comb begin
    unique case (c.src_b)
      SB_REG:  op_b = b_q;
      SB_FOUR: op_b = DATA_W'(4);
      SB_IMM:  op_b = imm_ext;
      default: op_b = {imm_ext[DATA_W-3:0], 2'b00};
    endcase
  end

  mcyc_alu #(.W(DATA_W)) u_alu (
    .a_i     (op_a),
    .b_i     (op_b),
    .op_i    (c.alu_op),
    .funct_i (ir_q[5:0]),
    .y_o     (alu_y),
    .zero_o  (alu_zero)
  );

  assign wa = c.reg_dst ? ir_q[15:11] : ir_q[20:16];
  assign wd = c.mem_to_reg ? mdr_q : alu_out_q;

  mcyc_regfile #(.W(DATA_W), .N(REG_N)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (ir_q[25:21]),
    .ra2_i  (ir_q[20:16]),
    .rd1_o  (rd1),
    .rd2_o  (rd2),
    .we_i   (c.reg_wr),
    .wa_i   (wa),
    .wd_i   (wd)
  );

  always_comb begin
    unique case (c.pc_src)
      PS_OUT:  pc_d = alu_out_q;
      PS_JMP:  pc_d = {pc_q[DATA_W-1:DATA_W-4], ir_q[25:0], 2'b00};
      default: pc_d = alu_y;
    endcase
  end

  assign pc_en = c.pc_wr | (c.pc_wr_cond & alu_zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= START_PC;
      ir_q      <= '0;
      mdr_q     <= '0;
      a_q       <= '0;
      b_q       <= '0;
      alu_out_q <= '0;
    end else begin
      if (pc_en)   pc_q <= pc_d;
      if (c.ir_wr) ir_q <= mem_rdata_i;
      mdr_q     <= c.mem_rd ? mem_rdata_i : '0;
      a_q       <= rd1;
      b_q       <= rd2;
      alu_out_q <= alu_y;
    end
  end

  assign mem_addr_o    = c.iord ? alu_out_q : pc_q;
  assign mem_wdata_o   = b_q;
  assign mem_rd_o      = c.mem_rd;
  assign mem_wr_o      = c.mem_wr;
  assign dbg_pc_o      = pc_q;
  assign dbg_ir_o      = ir_q;
  assign dbg_mdr_o     = mdr_q;
  assign dbg_a_o       = a_q;
  assign dbg_b_o       = b_q;
  assign dbg_alu_out_o = alu_out_q;
  assign iord_o        = c.iord;
  assign ir_wr_o       = c.ir_wr;
  assign src_a_o       = c.src_a;
  assign src_b_o       = c.src_b;
  assign alu_op_o      = c.alu_op;
  assign pc_src_o      = c.pc_src;
  assign pc_wr_o       = c.pc_wr;
  assign pc_wr_cond_o  = c.pc_wr_cond;
  assign reg_dst_o     = c.reg_dst;
  assign mem_to_reg_o  = c.mem_to_reg;
  assign reg_wr_o      = c.reg_wr;
endmodule

// File: rtl/mcyc_core_chk.sv
module mcyc_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc,
  input logic [31:0] ir,
  input logic [31:0] mdr,
  input logic [31:0] alu_out,
  input logic [31:0] mem_rdata,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        ir_wr,
  input logic        pc_wr,
  input logic        pc_wr_cond,
  input logic        reg_wr,
  input logic [1:0]  pc_src
);
  a_r1_fetch_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_wr && pc_wr && pc_src == 2'b00) |=> pc == $past(pc) + 32'd4);

  a_r1_ir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_wr |=> ir == $past(ir));

  a_r2_mdr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rd |=> mdr == 32'd0);

  a_r2_mdr_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd |=> mdr == $past(mem_rdata));

  a_r6_branch_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_cond && !pc_wr && pc_src == 2'b01) |=>
      (pc == $past(alu_out) || pc == $past(pc)));

  a_r7_jump_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr && pc_src == 2'b10) |=>
      pc == {$past(pc[31:28]), $past(ir[25:0]), 2'b00});

  a_r9_port_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd |-> !mem_wr);

  // R8 / R9: write-back cycles touch neither memory nor PC
  a_r8_wb_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr |-> (!mem_rd && !mem_wr && !pc_wr && !pc_wr_cond));
endmodule

bind mcyc_core mcyc_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc         (dbg_pc_o),
  .ir         (dbg_ir_o),
  .mdr        (dbg_mdr_o),
  .alu_out    (dbg_alu_out_o),
  .mem_rdata  (mem_rdata_i),
  .mem_rd     (mem_rd_o),
  .mem_wr     (mem_wr_o),
  .ir_wr      (ir_wr_o),
  .pc_wr      (pc_wr_o),
  .pc_wr_cond (pc_wr_cond_o),
  .reg_wr     (reg_wr_o),
  .pc_src     (pc_src_o)
);

// File: tb/mcyc_core_tb.sv
module mcyc_core_tb;
  localparam logic [31:0] START = 32'd4000;
  localparam int MEM_WORDS = 2048;
  localparam int N_CYC = 120;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr;
  logic [31:0] pc, ir, mdr, a, b, alo;
  logic        iord, ir_wr, src_a, pc_wr, pc_wr_cond, reg_dst, mem_to_reg, reg_wr;
  logic [1:0]  src_b, alu_op, pc_src;

  always #10 clk = ~clk;

  mcyc_core #(.START_PC(START)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .dbg_pc_o(pc), .dbg_ir_o(ir), .dbg_mdr_o(mdr), .dbg_a_o(a), .dbg_b_o(b),
    .dbg_alu_out_o(alo),
    .iord_o(iord), .ir_wr_o(ir_wr), .src_a_o(src_a), .src_b_o(src_b),
    .alu_op_o(alu_op), .pc_src_o(pc_src), .pc_wr_o(pc_wr),
    .pc_wr_cond_o(pc_wr_cond), .reg_dst_o(reg_dst), .mem_to_reg_o(mem_to_reg),
    .reg_wr_o(reg_wr)
  );

  logic [31:0] mem [MEM_WORDS];
  assign mem_rdata = mem[mem_addr[12:2]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[12:2]] <= mem_wdata;

  typedef struct packed {
    logic [15:0] ctrl;
    logic [31:0] pc, ir, mdr, a, b, alo;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$], taga_q[$], tagb_q[$];
  int    n_checks = 0, n_fail = 0;
  logic  done = 1'b0;

  // reference machine state
  logic [31:0] m_mem [MEM_WORDS];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc, m_ir, m_mdr, m_a, m_b, m_alo;
  int          m_ph;

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                        logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd,
                                        logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'b00000, fn};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'b000010, tgt};
  endfunction

  task automatic put(input logic [31:0] addr, input logic [31:0] w);
    mem[addr[12:2]]   = w;
    m_mem[addr[12:2]] = w;
  endtask

  // driver side: one expected entry per cycle, built from the requirements
  task automatic mdl_cycle();
    logic iord_m = 0, irw = 0, mrd = 0, mwr = 0, sa = 0;
    logic [1:0] sb = 0, ao = 0, ps = 0;
    logic pw = 0, pwc = 0, rdst = 0, m2r = 0, rw = 0;
    logic [31:0] sx, x, y, res, rdata, n_pc, n_mdr, n_ir, n_a, n_b;
    logic [4:0] dst;
    logic sub;
    string tag;
    exp_t e;
    case (m_ph)
      0: begin mrd = 1; irw = 1; sb = 2'b01; pw = 1; tag = "R1"; end
      1: begin sb = 2'b11; tag = "R5"; end
      2: begin sa = 1; ao = 2'b10; tag = "R8"; end
      3: begin rdst = 1; rw = 1; tag = "R8"; end
      4: begin sa = 1; sb = 2'b10; tag = "R9"; end
      5: begin mrd = 1; iord_m = 1; tag = "R9"; end
      6: begin m2r = 1; rw = 1; tag = "R9"; end
      7: begin iord_m = 1; mwr = 1; tag = "R9"; end
      8: begin sa = 1; ao = 2'b01; pwc = 1; ps = 2'b01; tag = "R6"; end
      default: begin pw = 1; ps = 2'b10; tag = "R7"; end
    endcase
    sx = {{16{m_ir[15]}}, m_ir[15:0]};
    x  = sa ? m_a : m_pc;
    case (sb)
      2'b00: y = m_b;
      2'b01: y = 32'd4;
      2'b10: y = sx;
      default: y = sx << 2;
    endcase
    sub   = (ao == 2'b01) || (ao == 2'b10 && m_ir[5:0] == 6'b100010);
    res   = sub ? x - y : x + y;
    rdata = iord_m ? m_mem[m_alo[12:2]] : m_mem[m_pc[12:2]];
    n_mdr = mrd ? rdata : 32'd0;
    n_ir  = irw ? rdata : m_ir;
    n_a   = m_rf[m_ir[25:21]];
    n_b   = m_rf[m_ir[20:16]];
    n_pc  = m_pc;
    if (pw || (pwc && res == 32'd0)) begin
      case (ps)
        2'b00:   n_pc = res;
        2'b01:   n_pc = m_alo;
        default: n_pc = {m_pc[31:28], m_ir[25:0], 2'b00};
      endcase
    end
    taga_q.push_back(m_ir[25:21] == 5'd0 ? "R10" : "R3");
    tagb_q.push_back(m_ir[20:16] == 5'd0 ? "R10" : "R3");
    if (rw) begin
      dst = rdst ? m_ir[15:11] : m_ir[20:16];
      if (dst != 5'd0) m_rf[dst] = m2r ? m_mdr : m_alo;  // R10: r0 never written
    end
    if (mwr) m_mem[m_alo[12:2]] = m_b;
    e.ctrl = {iord_m, irw, mrd, mwr, sa, sb, ao, ps, pw, pwc, rdst, m2r, rw};
    e.pc = n_pc; e.ir = n_ir; e.mdr = n_mdr; e.a = n_a; e.b = n_b; e.alo = res;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    case (m_ph)
      0: m_ph = 1;
      1: case (m_ir[31:26])
           6'b000000: m_ph = 2;
           6'b100011, 6'b101011: m_ph = 4;
           6'b000100: m_ph = 8;
           6'b000010: m_ph = 9;
           default: m_ph = 0;
         endcase
      2: m_ph = 3;
      4: m_ph = (m_ir[31:26] == 6'b100011) ? 5 : 7;
      5: m_ph = 6;
      default: m_ph = 0;
    endcase
    m_pc = n_pc; m_ir = n_ir; m_mdr = n_mdr; m_a = n_a; m_b = n_b; m_alo = res;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  // monitor
  initial begin
    logic [15:0] ctl;
    exp_t e;
    string t;
    for (int i = 0; i < MEM_WORDS; i++) begin
      mem[i] = 32'd0;
      m_mem[i] = 32'd0;
    end
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    put(32'd7000, 32'd8);
    put(32'd7004, 32'd4);
    put(32'd7008, 32'd7100);
    put(32'd7012, 32'd7200);
    put(32'd7104, 32'd82);
    put(32'd7108, 32'd134);
    put(32'd4000, enc_i(6'b100011, 5'd0, 5'd16, 16'd7000));
    put(32'd4004, enc_i(6'b100011, 5'd0, 5'd17, 16'd7004));
    put(32'd4008, enc_i(6'b100011, 5'd0, 5'd18, 16'd7008));
    put(32'd4012, enc_i(6'b100011, 5'd0, 5'd19, 16'd7012));
    put(32'd4016, enc_r(5'd17, 5'd17, 5'd0, 6'b100000));   // write aimed at r0
    put(32'd4020, enc_i(6'b000100, 5'd16, 5'd0, 16'd6));
    put(32'd4024, enc_r(5'd16, 5'd18, 5'd8, 6'b100000));
    put(32'd4028, enc_r(5'd16, 5'd19, 5'd9, 6'b100000));
    put(32'd4032, enc_i(6'b100011, 5'd8, 5'd10, 16'd0));
    put(32'd4036, enc_i(6'b101011, 5'd9, 5'd10, 16'd0));
    put(32'd4040, enc_r(5'd16, 5'd17, 5'd16, 6'b100010));
    put(32'd4044, enc_j(26'd1005));
    put(32'd4048, enc_j(26'd1012));
    m_pc = START; m_ir = 0; m_mdr = 0; m_a = 0; m_b = 0; m_alo = 0; m_ph = 0;
    for (int i = 0; i < N_CYC; i++) mdl_cycle();

    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "pc", pc, START);
    chk("R11", "ir", ir, 32'd0);
    chk("R11", "mdr", mdr, 32'd0);
    chk("R11", "alu_out", alo, 32'd0);
    chk("R11", "fetch_ctrl", {30'd0, ir_wr, mem_rd}, 32'd3);
    rst_ni = 1'b1;

    for (int i = 0; i < N_CYC; i++) begin
      ctl = {iord, ir_wr, mem_rd, mem_wr, src_a, src_b, alu_op, pc_src,
             pc_wr, pc_wr_cond, reg_dst, mem_to_reg, reg_wr};
      @(negedge clk);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, "ctrl", {16'd0, ctl}, {16'd0, e.ctrl});
      chk(t, "pc", pc, e.pc);
      chk("R1", "ir", ir, e.ir);
      chk("R2", "mdr", mdr, e.mdr);
      chk(taga_q.pop_front(), "a", a, e.a);
      chk(tagb_q.pop_front(), "b", b, e.b);
      chk("R4", "alu_out", alo, e.alo);
    end

    // R9: stored copies, R7: parked in exit jump loop
    chk("R9", "mem7208", mem[32'd7208 >> 2], 32'd134);
    chk("R9", "mem7204", mem[32'd7204 >> 2], 32'd82);
    chk("R9", "mem7200", mem[32'd7200 >> 2], 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule